// File: doc/BRIEF.md
# Context Probability Model Store with Successor Lookahead

This block keeps the adaptive probability model of every context used by a one-bin-per-cycle binary arithmetic decoder. Each model is a 6-bit probability state, the value of the more probable symbol (MPS) and a stored flag that is high when the state is not zero. The decoder asks for a context index. One cycle later it receives that context's model. In the cycle it resolves the bin, it returns the bin value. The store builds both possible successor models from the presented model before the bin is known: the one for an MPS outcome and the one for a less probable symbol (LPS) outcome. The bin then picks one of the two through a single select.

A chosen successor travels through two pending stages before it lands in the array. A request for a context whose update is still in flight is served from the newest copy: the successor being committed in the same cycle, then pending stage one, then pending stage two, then the array. A slice reset pulse reloads every context, one per cycle, from an initialization port. The block raises a busy output for that whole pass and drops any pending update and any presented model.

Requests use a valid/ready handshake. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. The presented model counts as a stream output that the bin consumes. The store applies back-pressure: while a model is presented and no bin is given, `req_ready` is low and the model holds. The init port and the busy flag are plain control pins.

Top module: `ctxm_store`

## Requirements
- R1: One cycle after `init_start`, `init_busy` is high for exactly N_CTX cycles while `init_idx` counts 0, 1, … N_CTX-1. In each busy cycle, context `init_idx` is loaded with `init_state`/`init_mps`. Its stored nonzero flag becomes 1 exactly when the loaded state is not 0.
- R2: A request taken on a clock edge presents that context's current model on `mdl_state`/`mdl_mps`/`mdl_nz` with `mdl_valid` high in the next cycle.
- R3: `req_ready` is high only when `init_busy` is low, `init_start` is low, and either `mdl_valid` is low or `bin_valid` is high. While `mdl_valid` is high and `bin_valid` is low, the presented model stays unchanged.
- R4: The bin is treated as the MPS when `bin_val` equals `mdl_mps`. The MPS successor keeps the MPS. Its state is s+1 for s below 62, and s is kept for s of 62 or 63.
- R5: On an LPS bin (`bin_val` differs from `mdl_mps`), the successor state is s - floor((s+3)/4) for s below 63, and 63 stays 63. The MPS value is inverted when s is 0.
- R6: A bin given while `mdl_valid` is high commits the successor to the presented context. Any later request for that context, even in the same cycle or the next, returns the committed model.
- R7: `bin_valid` while `mdl_valid` is low changes no stored model.
- R8: `init_start` drops `mdl_valid` on the next cycle. It discards the bin of that cycle and all pending updates, so after the pass every context holds its freshly loaded value.
- R9: After reset, `init_busy` and `mdl_valid` are low and `req_ready` is high while the inputs are idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_start | input | 1 | Slice reset pulse, starts a full reload |
| init_state | input | 6 | State loaded into context `init_idx` |
| init_mps | input | 1 | MPS value loaded into context `init_idx` |
| init_busy | output | 1 | High while the reload pass runs |
| init_idx | output | 9 | Context being loaded this cycle |
| req_valid | input | 1 | Context request valid |
| req_ready | output | 1 | Request can be taken |
| req_ctx | input | 9 | Requested context index |
| mdl_valid | output | 1 | A model is presented |
| mdl_state | output | 6 | Presented probability state |
| mdl_mps | output | 1 | Presented MPS value |
| mdl_nz | output | 1 | Presented state-is-nonzero flag |
| bin_valid | input | 1 | Decoded bin is returned this cycle |
| bin_val | input | 1 | Decoded bin value |

## Verification
Two things can happen in the same cycle: a bin commits a successor for the presented context, and a new request reads a context, possibly the same one, from storage. The bench provokes this by drawing most requests from a small pool of contexts, including the ones whose loaded state is 0 or 63, with frequent immediate repeats. Its reference is a plain array. Each bin updates the array at once, before the same cycle's read is resolved. Any stale value that a missed forward lets through therefore shows as a mismatch on the presented model. A second overlap, a slice reset in a cycle that also carries a bin, is provoked mid-traffic. It is judged by the values that the contexts show after the reload.

// File: rtl/ctxm_pkg.sv
package ctxm_pkg;
  localparam int STW = 6;
  localparam logic [STW-1:0] ST_TOP   = 6'd63;
  localparam logic [STW-1:0] ST_CEIL  = 6'd62;

  typedef struct packed {
    logic [STW-1:0] state;
    logic           mps;
    logic           nz;
  } model_t;

  localparam int MW = $bits(model_t);

  function automatic model_t mk_model(logic [STW-1:0] st, logic mps);
    model_t m;
    m.state = st;
    m.mps   = mps;
    m.nz    = (st != '0);
    return m;
  endfunction

  // transition after a more-probable outcome
  function automatic logic [STW-1:0] mps_step(logic [STW-1:0] s);
    return (s < ST_CEIL) ? s + 6'd1 : s;
  endfunction

  // transition after a less-probable outcome
  function automatic logic [STW-1:0] lps_step(logic [STW-1:0] s);
    logic [STW:0] q;
    q = ({1'b0, s} + 7'd3) >> 2;
    return (s == ST_TOP) ? s : s - q[STW-1:0];
  endfunction
endpackage

// File: rtl/ctxm_ram.sv
module ctxm_ram #(
  parameter int DEPTH = 399,
  parameter int AW    = 9,
  parameter int W     = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/ctxm_succ.sv
module ctxm_succ
  import ctxm_pkg::*;
(
  input  model_t cur,
  input  logic   bin,
  output model_t nxt
);
  model_t on_mps, on_lps;

  always_comb begin
    on_mps = mk_model(mps_step(cur.state), cur.mps);
    on_lps = mk_model(lps_step(cur.state), cur.nz ? cur.mps : ~cur.mps);
    nxt    = (bin == cur.mps) ? on_mps : on_lps;
  end
endmodule

// File: rtl/ctxm_init_seq.sv
module ctxm_init_seq #(
  parameter int N  = 399,
  parameter int AW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          busy,
  output logic [AW-1:0] idx
);
  localparam logic [AW-1:0] LAST = AW'(N - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      idx  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      idx  <= '0;
    end else if (busy) begin
      if (idx == LAST) busy <= 1'b0;
      else             idx  <= idx + 1'b1;
    end
  end

  p_init_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && idx != LAST && !start) |=> (busy && idx == $past(idx) + 1'b1));
  p_init_end_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && idx == LAST && !start) |=> !busy);
endmodule

// File: rtl/ctxm_store.sv
module ctxm_store
  import ctxm_pkg::*;
#(
  parameter  int N_CTX = 399,
  localparam int AW    = (N_CTX > 1) ? $clog2(N_CTX) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          init_start,
  input  logic [5:0]    init_state,
  input  logic          init_mps,
  output logic          init_busy,
  output logic [AW-1:0] init_idx,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_ctx,
  output logic          mdl_valid,
  output logic [5:0]    mdl_state,
  output logic          mdl_mps,
  output logic          mdl_nz,
  input  logic          bin_valid,
  input  logic          bin_val
);
  model_t          out_m, succ_m, rd_m, p1_m, p2_m, wr_m;
  logic            out_v, p1_v, p2_v;
  logic [AW-1:0]   out_ctx, p1_ctx, p2_ctx, wr_addr;
  logic [MW-1:0]   mem_rd;
  logic            acc, commit, wr_en;

  ctxm_init_seq #(.N(N_CTX), .AW(AW)) u_init (
    .clk(clk), .rst_n(rst_n), .start(init_start),
    .busy(init_busy), .idx(init_idx)
  );

  // both candidates are built from the presented model; bin picks one
  ctxm_succ u_succ (.cur(out_m), .bin(bin_val), .nxt(succ_m));

  assign req_ready = !init_busy && !init_start && (!out_v || bin_valid);
  assign acc       = req_valid && req_ready;
  assign commit    = out_v && bin_valid;

  // array write: reload pass has the port, otherwise the oldest pending stage
  always_comb begin
    wr_en   = init_busy || p2_v;
    wr_addr = init_busy ? init_idx : p2_ctx;
    wr_m    = init_busy ? mk_model(init_state, init_mps) : p2_m;
  end

  ctxm_ram #(.DEPTH(N_CTX), .AW(AW), .W(MW)) u_ram (
    .clk(clk), .we(wr_en), .waddr(wr_addr), .wdata(wr_m),
    .raddr(req_ctx), .rdata(mem_rd)
  );

  // newest copy wins: same-cycle commit, then pending stages, then array
  always_comb begin
    if (commit && out_ctx == req_ctx)    rd_m = succ_m;
    else if (p1_v && p1_ctx == req_ctx)  rd_m = p1_m;
    else if (p2_v && p2_ctx == req_ctx)  rd_m = p2_m;
    else                                 rd_m = model_t'(mem_rd);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_v   <= 1'b0;
      out_ctx <= '0;
      out_m   <= '0;
      p1_v    <= 1'b0;
      p1_ctx  <= '0;
      p1_m    <= '0;
      p2_v    <= 1'b0;
      p2_ctx  <= '0;
      p2_m    <= '0;
    end else begin
      p1_v   <= commit && !init_start;
      p1_ctx <= out_ctx;
      p1_m   <= succ_m;
      p2_v   <= p1_v && !init_start;
      p2_ctx <= p1_ctx;
      p2_m   <= p1_m;
      if (init_start) begin
        out_v <= 1'b0;
      end else if (acc) begin
        out_v   <= 1'b1;
        out_ctx <= req_ctx;
        out_m   <= rd_m;
      end else if (commit) begin
        out_v <= 1'b0;
      end
    end
  end

  assign mdl_valid = out_v;
  assign mdl_state = out_m.state;
  assign mdl_mps   = out_m.mps;
  assign mdl_nz    = out_m.nz;

  p_nz_flag_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_v |-> (out_m.nz == (out_m.state != '0)));
  p_present_r2: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_v);
  p_busy_block_r3: assert property (@(posedge clk) disable iff (!rst_n)
    init_busy |-> !req_ready);
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_v && !bin_valid && !init_start) |=> (out_v && $stable(out_m)));
  p_mps_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && bin_val == out_m.mps) |=> (p1_m.mps == $past(out_m.mps)));
  p_mps_swap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && bin_val != out_m.mps && out_m.state == '0) |=> (p1_m.mps != $past(out_m.mps)));
  p_reload_kill_r8: assert property (@(posedge clk) disable iff (!rst_n)
    init_start |=> (!out_v && !p1_v));
endmodule

// File: tb/ctxm_store_bench.sv
module ctxm_store_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 399;
  localparam int AW = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic init_start = 1'b0, init_mps = 1'b0;
  logic [5:0] init_state = '0;
  logic init_busy;
  logic [AW-1:0] init_idx;
  logic req_valid = 1'b0, req_ready;
  logic [AW-1:0] req_ctx = '0;
  logic mdl_valid, mdl_mps, mdl_nz;
  logic [5:0] mdl_state;
  logic bin_valid = 1'b0, bin_val = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ctxm_store #(.N_CTX(N)) u_ctxm_store (
    .clk(clk), .rst_n(rst_n), .init_start(init_start), .init_state(init_state),
    .init_mps(init_mps), .init_busy(init_busy), .init_idx(init_idx),
    .req_valid(req_valid), .req_ready(req_ready), .req_ctx(req_ctx),
    .mdl_valid(mdl_valid), .mdl_state(mdl_state), .mdl_mps(mdl_mps), .mdl_nz(mdl_nz),
    .bin_valid(bin_valid), .bin_val(bin_val)
  );

  int compared = 0, mismatched = 0;
  bit finished = 0;

  logic [5:0] ref_st [N];
  logic       ref_mps [N];
  bit         exp_v = 0;
  int         exp_ctx = 0;
  logic [5:0] exp_st = '0;
  logic       exp_mps = 0;
  int         busy_cnt = 0, exp_idx = 0, gen = 0, last_ctx = 0;

  function automatic logic [5:0] ini_st(int i, int g);
    return 6'((i * 7 + 3 + g * 11) % 64);
  endfunction
  function automatic logic ini_mps(int i, int g);
    return 1'(((i >> 1) ^ g) & 1);
  endfunction
  function automatic logic [5:0] nx_mps(logic [5:0] s);
    return (s < 6'd62) ? s + 6'd1 : s;
  endfunction
  function automatic logic [5:0] nx_lps(logic [5:0] s);
    int t;
    t = int'(s);
    return (s == 6'd63) ? s : 6'(t - (t + 3) / 4);
  endfunction

  task automatic check(bit ok, string tag, int act, int expv);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, expv, $time);
    end
  endtask

  // one cycle: called at a negedge, checks outputs, drives inputs, advances reference
  task automatic step(bit rv, int rc, bit bv, bit bb, bit is);
    bit rdy, cm;
    check(init_busy == (busy_cnt > 0), "R1 busy", int'(init_busy), int'(busy_cnt > 0));
    if (busy_cnt > 0) check(int'(init_idx) == exp_idx, "R1 init_idx", int'(init_idx), exp_idx);
    check(mdl_valid == exp_v, "R2 mdl_valid", int'(mdl_valid), int'(exp_v));
    if (exp_v) begin
      check(mdl_state == exp_st, "R4 R5 R6 state", int'(mdl_state), int'(exp_st));
      check(mdl_mps == exp_mps, "R4 R5 R6 mps", int'(mdl_mps), int'(exp_mps));
      check(mdl_nz == (exp_st != 0), "R1 nz", int'(mdl_nz), int'(exp_st != 0));
    end
    init_start = is; req_valid = rv; req_ctx = AW'(rc);
    bin_valid = bv; bin_val = bb;
    if (busy_cnt > 0) begin
      init_state = ini_st(exp_idx, gen);
      init_mps   = ini_mps(exp_idx, gen);
    end
    #1;
    rdy = (busy_cnt == 0) && !is && (!exp_v || bv);
    check(req_ready == rdy, "R3 req_ready", int'(req_ready), int'(rdy));
    if (busy_cnt > 0) begin
      ref_st[exp_idx]  = ini_st(exp_idx, gen);
      ref_mps[exp_idx] = ini_mps(exp_idx, gen);
      exp_idx++;
      busy_cnt--;
    end
    if (is) begin
      busy_cnt = N; exp_idx = 0; exp_v = 0;   // R8: presented model and bin dropped
    end else begin
      cm = exp_v && bv;                       // R7: bin without a model does nothing
      if (cm) begin
        if (bb == ref_mps[exp_ctx]) ref_st[exp_ctx] = nx_mps(ref_st[exp_ctx]);
        else begin
          if (ref_st[exp_ctx] == 0) ref_mps[exp_ctx] = ~ref_mps[exp_ctx];
          ref_st[exp_ctx] = nx_lps(ref_st[exp_ctx]);
        end
      end
      if (rv && rdy) begin
        exp_v = 1; exp_ctx = rc; exp_st = ref_st[rc]; exp_mps = ref_mps[rc];
      end else if (cm) exp_v = 0;
    end
    @(negedge clk);
  endtask

  function automatic int pick_ctx();
    int r;
    r = int'($urandom % 8);
    case (r)
      0: return 0;
      1: return 27;       // loads state 0 in first pass
      2: return 36;       // loads state 63 in first pass
      3: return N - 1;
      4, 5: return last_ctx;
      default: return int'($urandom % N);
    endcase
  endfunction

  task automatic traffic(int cycles);
    for (int k = 0; k < cycles; k++) begin
      int c;
      c = pick_ctx();
      last_ctx = c;
      step(($urandom % 5) != 0, c, ($urandom % 4) != 0, 1'($urandom % 2), 1'b0);
    end
  endtask

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9: idle state after reset
    check(!init_busy, "R9 busy", int'(init_busy), 0);
    check(!mdl_valid, "R9 mdl_valid", int'(mdl_valid), 0);
    check(req_ready, "R9 req_ready", int'(req_ready), 1);
    // R1: first reload pass, requests and stray bins during it (R3, R7)
    gen = 0;
    step(1'b0, 0, 1'b0, 1'b0, 1'b1);
    for (int k = 0; k < N; k++) step(1'($urandom % 2), 5, 1'($urandom % 2), 1'b0, 1'b0);
    // R7: bin with no model, then read the same context
    step(1'b0, 27, 1'b1, 1'b1, 1'b0);
    step(1'b1, 27, 1'b1, 1'b1, 1'b0);
    // R5 R6: hammer context 27 (state 0) with LPS and MPS bins back to back
    for (int k = 0; k < 8; k++) step(1'b1, 27, 1'b1, 1'(k % 3 == 0), 1'b0);
    // R3: hold without a bin
    for (int k = 0; k < 4; k++) step(1'b1, 36, 1'b0, 1'b0, 1'b0);
    traffic(3000);
    // R8: reload while a model is presented and a bin arrives
    gen = 1;
    step(1'b1, 3, 1'b1, 1'b1, 1'b0);
    step(1'b1, 3, 1'b1, 1'b0, 1'b1);
    for (int k = 0; k < N; k++) step(1'b1, 3, 1'b1, 1'b0, 1'b0);
    traffic(2000);
    step(1'b0, 0, 1'b1, 1'b0, 1'b0);
    step(1'b0, 0, 1'b0, 1'b0, 1'b0);
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      finished = 1;
      compared++; mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule